// File: doc/BRIEF.md
# Priority Interrupt and Trap Arbiter

This block decides which pending event a small CPU core takes next, and it performs the context switch into and out of the handler. Peripheral request lines each carry a fixed level from 4 to 7. Internal trap conditions outrank every device. A device is eligible only when its level is strictly above the 3-bit processor priority held in the status word. A registered "event pending" flag is offered to the core, and the block starts an entry only on a cycle where the core signals an instruction boundary.

An entry first saves the core's PC and the current status word on a small internal save stack. It then reads the handler PC from the winning vector address and the new status word from that address plus 2, each read using a request/acknowledge handshake. At the end it loads the handler PC into the core, installs the new status word, and pulses an acknowledge to the winning source so that source can drop its request. A return strobe pops the most recent saved pair and restores both values. The core can also write the status word directly while the block is idle.

Top module: `irq_trap_arbiter`

## Requirements
- R1: A device request of level L is taken only when L > psw_out[7:5]. A device with L equal to or below that priority stays pending and starts no entry.
- R2: A pending trap is taken at any processor priority, including 7, and wins over every pending device.
- R3: Trap sources, by trap_req bit 0..10, have vectors octal 004, 010, 014, 020, 024, 030, 034, 114, 240, 244, 250. When several traps are pending, the lowest vector wins.
- R4: Device sources, by dev_req bit 0..7, have vector/level pairs (octal) 060/4, 064/4, 070/4, 074/4, 100/6, 104/6, 200/4, 220/5. The highest eligible level wins, and among equal levels the lower vector wins.
- R5: irq_pending is a registered flag: it goes high one clock after an eligible request appears. An entry starts only at a clock where insn_boundary is high and irq_pending is high.
- R6: An entry reads mem_addr = vector and then mem_addr = vector + 2. mem_req and mem_addr stay stable until mem_ack.
- R7: An entry ends with a one-cycle pc_load pulse, with pc_out set to the first word read. psw_out takes the second word read, except that bits 13:12 are replaced by the old psw_out bits 15:14. In the same cycle exactly one bit of dev_ack or trap_ack pulses, for the winner.
- R8: rtt_strobe pops the most recent saved PC and status word. pc_out takes the saved PC with a pc_load pulse, and psw_out takes the saved status word, in LIFO order across nested entries.
- R9: rtt_strobe with nothing saved is ignored: no pc_load pulse, and psw_out is unchanged.
- R10: When SAVE_DEPTH contexts are saved, a further event stays pending and starts no entry until a return frees a slot.
- R11: After reset psw_out is 0, and busy, mem_req, pc_load, irq_pending and all acks are 0.
- R12: psw_wr with psw_wdata loads psw_out on the next clock while no entry is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NDEV | Level-held device requests |
| dev_ack | output | NDEV | One-cycle grant pulse to the taken device |
| trap_req | input | NTRAP | Level-held trap conditions |
| trap_ack | output | NTRAP | One-cycle grant pulse to the taken trap |
| insn_boundary | input | 1 | Core is between instructions |
| rtt_strobe | input | 1 | Return from handler |
| cur_pc | input | DW | Core PC to save on entry |
| psw_wr | input | 1 | Status word write enable |
| psw_wdata | input | DW | Status word write data |
| irq_pending | output | 1 | Registered eligible-event flag |
| busy | output | 1 | Entry sequence in progress |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | DW | Vector read address |
| mem_ack | input | 1 | Vector read acknowledge, data valid |
| mem_rdata | input | DW | Vector read data |
| pc_load | output | 1 | Load pc_out into the core PC |
| pc_out | output | DW | PC value for the core |
| psw_out | output | DW | Current processor status word |

## Verification
The bench aims at the strict comparison between level and priority. A device whose level equals the priority must stay pending; a design using >= would take it and issue a read that is not expected. It also checks that a trap is taken at priority 7 ahead of a device, and that ties are broken toward the lower vector. A design that got either wrong would fetch from the wrong vector and send its acknowledge to the wrong source. Other targets are the previous-mode substitution (the stored value carries different bits there), returns in LIFO order after nesting, a return with nothing saved, and a full save stack. A design that overran the stack would start a fifth entry, and one that popped an empty stack would emit a spurious pc_load.

// File: rtl/ita_pkg.sv
package ita_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_GET_PC,
      SEQ_GET_PS
   } seq_state_e;

   localparam int PRI_W   = 3;
   localparam int PRI_LSB = 5;
   localparam int MIN_DEV_LVL = 4;
   localparam int MAX_LVL     = 7;

   localparam int N_DEV_DEF  = 8;
   localparam int N_TRAP_DEF = 11;

   localparam int DEV_VEC_DEF [N_DEV_DEF] =
      '{'o60, 'o64, 'o70, 'o74, 'o100, 'o104, 'o200, 'o220};
   localparam int DEV_LVL_DEF [N_DEV_DEF] =
      '{4, 4, 4, 4, 6, 6, 4, 5};
   localparam int TRAP_VEC_DEF [N_TRAP_DEF] =
      '{'o4, 'o10, 'o14, 'o20, 'o24, 'o30, 'o34, 'o114, 'o240, 'o244, 'o250};

endpackage

// File: rtl/ita_pick.sv
module ita_pick #(
   parameter int NDEV  = 8,
   parameter int NTRAP = 11,
   parameter int DW    = 16,
   parameter int DEV_VEC  [NDEV]  = ita_pkg::DEV_VEC_DEF,
   parameter int DEV_LVL  [NDEV]  = ita_pkg::DEV_LVL_DEF,
   parameter int TRAP_VEC [NTRAP] = ita_pkg::TRAP_VEC_DEF
) (
   input  logic [NDEV-1:0]           dev_req,
   input  logic [NTRAP-1:0]          trap_req,
   input  logic [ita_pkg::PRI_W-1:0] cur_pri,
   output logic                      win_valid,
   output logic                      win_trap,
   output logic [NDEV-1:0]           win_dev_oh,
   output logic [NTRAP-1:0]          win_trap_oh,
   output logic [DW-1:0]             win_vec
);

   // elaboration-time checks on the source tables
   for (genvar i = 0; i < NDEV; i++) begin : g_dev_chk
      if (DEV_LVL[i] < ita_pkg::MIN_DEV_LVL || DEV_LVL[i] > ita_pkg::MAX_LVL) begin : g_bad_lvl
         $error("device level out of the 4..7 bus range");
      end
      if (DEV_VEC[i] % 4 != 0) begin : g_bad_vec
         $error("device vector not word-pair aligned");
      end
      if (i > 0) begin : g_order
         if (DEV_VEC[i] <= DEV_VEC[i-1]) begin : g_bad_order
            $error("device vectors must ascend with index");
         end
      end
   end
   for (genvar i = 1; i < NTRAP; i++) begin : g_trap_chk
      if (TRAP_VEC[i] <= TRAP_VEC[i-1]) begin : g_bad_order
         $error("trap vectors must ascend with index");
      end
   end

   logic [NDEV-1:0]  dev_elig;
   logic [NTRAP-1:0] t_oh;
   logic [DW-1:0]    t_vec;
   logic [NDEV-1:0]  d_oh;
   logic [DW-1:0]    d_vec;
   logic             d_found;
   int               d_lvl;

   for (genvar i = 0; i < NDEV; i++) begin : g_elig
      assign dev_elig[i] = dev_req[i] && (DEV_LVL[i] > int'(cur_pri));
   end

   // lowest set trap bit = lowest trap vector
   assign t_oh = trap_req & (~trap_req + NTRAP'(1));

   always_comb begin
      t_vec = '0;
      for (int i = 0; i < NTRAP; i++) begin
         if (t_oh[i]) t_vec = DW'(TRAP_VEC[i]);
      end
   end

   // scan downward; >= lets a lower index take over an equal level
   always_comb begin
      d_found = 1'b0;
      d_lvl   = 0;
      d_oh    = '0;
      d_vec   = '0;
      for (int i = NDEV - 1; i >= 0; i--) begin
         if (dev_elig[i] && (!d_found || DEV_LVL[i] >= d_lvl)) begin
            d_found  = 1'b1;
            d_lvl    = DEV_LVL[i];
            d_oh     = '0;
            d_oh[i]  = 1'b1;
            d_vec    = DW'(DEV_VEC[i]);
         end
      end
   end

   assign win_trap    = |trap_req;
   assign win_valid   = win_trap || d_found;
   assign win_trap_oh = t_oh;
   assign win_dev_oh  = win_trap ? '0 : d_oh;
   assign win_vec     = win_trap ? t_vec : d_vec;

endmodule

// File: rtl/ita_ctx_stack.sv
module ita_ctx_stack #(
   parameter int DEPTH = 4,
   parameter int DW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] in_pc,
   input  logic [DW-1:0] in_psw,
   output logic [DW-1:0] top_pc,
   output logic [DW-1:0] top_psw,
   output logic          empty,
   output logic          full
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("save stack needs at least one slot");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         cnt <= cnt + CW'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   if (DEPTH == 1) begin : g_single
      logic [DW-1:0] pc_r, psw_r;
      always_ff @(posedge clk) begin
         if (push && !full) begin
            pc_r  <= in_pc;
            psw_r <= in_psw;
         end
      end
      assign top_pc  = pc_r;
      assign top_psw = psw_r;
   end else begin : g_array
      logic [DW-1:0] pc_m  [DEPTH];
      logic [DW-1:0] psw_m [DEPTH];
      logic [IW-1:0] wr_idx, rd_idx;
      assign wr_idx = IW'(cnt);
      assign rd_idx = IW'(cnt - CW'(1));
      always_ff @(posedge clk) begin
         if (push && !full) begin
            pc_m[wr_idx]  <= in_pc;
            psw_m[wr_idx] <= in_psw;
         end
      end
      assign top_pc  = pc_m[rd_idx];
      assign top_psw = psw_m[rd_idx];
   end

   // R10
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R9
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/irq_trap_arbiter.sv
module irq_trap_arbiter #(
   parameter int NDEV       = ita_pkg::N_DEV_DEF,
   parameter int NTRAP      = ita_pkg::N_TRAP_DEF,
   parameter int DW         = 16,
   parameter int SAVE_DEPTH = 4,
   parameter int DEV_VEC  [NDEV]  = ita_pkg::DEV_VEC_DEF,
   parameter int DEV_LVL  [NDEV]  = ita_pkg::DEV_LVL_DEF,
   parameter int TRAP_VEC [NTRAP] = ita_pkg::TRAP_VEC_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NDEV-1:0]  dev_req,
   output logic [NDEV-1:0]  dev_ack,
   input  logic [NTRAP-1:0] trap_req,
   output logic [NTRAP-1:0] trap_ack,
   input  logic             insn_boundary,
   input  logic             rtt_strobe,
   input  logic [DW-1:0]    cur_pc,
   input  logic             psw_wr,
   input  logic [DW-1:0]    psw_wdata,
   output logic             irq_pending,
   output logic             busy,
   output logic             mem_req,
   output logic [DW-1:0]    mem_addr,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             pc_load,
   output logic [DW-1:0]    pc_out,
   output logic [DW-1:0]    psw_out
);
   import ita_pkg::*;

   localparam int CM_LSB = DW - 2;   // current mode field
   localparam int PM_LSB = DW - 4;   // previous mode field

   if (DW < 16) begin : g_bad_dw
      $error("status word must be at least 16 bits");
   end

   seq_state_e       state;
   logic [DW-1:0]    psw_q;
   logic [DW-1:0]    vec_q, new_pc_q, old_pc_q, old_psw_q;
   logic [NDEV-1:0]  dev_oh_q;
   logic [NTRAP-1:0] trap_oh_q;
   logic [DW-1:0]    psw_entry;

   logic             win_valid, win_trap;
   logic [NDEV-1:0]  win_dev_oh;
   logic [NTRAP-1:0] win_trap_oh;
   logic [DW-1:0]    win_vec;
   logic [DW-1:0]    top_pc, top_psw;
   logic             stk_empty, stk_full;
   logic             start, do_rtt, push;

   ita_pick #(
      .NDEV(NDEV), .NTRAP(NTRAP), .DW(DW),
      .DEV_VEC(DEV_VEC), .DEV_LVL(DEV_LVL), .TRAP_VEC(TRAP_VEC)
   ) i_pick (
      .dev_req     (dev_req),
      .trap_req    (trap_req),
      .cur_pri     (psw_q[PRI_LSB +: PRI_W]),
      .win_valid   (win_valid),
      .win_trap    (win_trap),
      .win_dev_oh  (win_dev_oh),
      .win_trap_oh (win_trap_oh),
      .win_vec     (win_vec)
   );

   ita_ctx_stack #(.DEPTH(SAVE_DEPTH), .DW(DW)) i_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .pop     (do_rtt),
      .in_pc   (old_pc_q),
      .in_psw  (old_psw_q),
      .top_pc  (top_pc),
      .top_psw (top_psw),
      .empty   (stk_empty),
      .full    (stk_full)
   );

   assign start  = (state == SEQ_IDLE) && insn_boundary && irq_pending
                   && win_valid && !stk_full;
   assign do_rtt = (state == SEQ_IDLE) && !start && rtt_strobe && !stk_empty;
   assign push   = (state == SEQ_GET_PS) && mem_ack;

   always_comb begin
      psw_entry = mem_rdata;
      psw_entry[PM_LSB +: 2] = old_psw_q[CM_LSB +: 2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SEQ_IDLE;
         psw_q       <= '0;
         vec_q       <= '0;
         new_pc_q    <= '0;
         old_pc_q    <= '0;
         old_psw_q   <= '0;
         dev_oh_q    <= '0;
         trap_oh_q   <= '0;
         pc_out      <= '0;
         pc_load     <= 1'b0;
         dev_ack     <= '0;
         trap_ack    <= '0;
         irq_pending <= 1'b0;
      end else begin
         pc_load     <= 1'b0;
         dev_ack     <= '0;
         trap_ack    <= '0;
         irq_pending <= win_valid;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state     <= SEQ_GET_PC;
                  vec_q     <= win_vec;
                  dev_oh_q  <= win_dev_oh;
                  trap_oh_q <= win_trap_oh;
                  old_pc_q  <= cur_pc;
                  old_psw_q <= psw_q;
               end else if (do_rtt) begin
                  pc_out  <= top_pc;
                  psw_q   <= top_psw;
                  pc_load <= 1'b1;
               end else if (psw_wr) begin
                  psw_q <= psw_wdata;
               end
            end
            SEQ_GET_PC: begin
               if (mem_ack) begin
                  new_pc_q <= mem_rdata;
                  state    <= SEQ_GET_PS;
               end
            end
            SEQ_GET_PS: begin
               if (mem_ack) begin
                  psw_q    <= psw_entry;
                  pc_out   <= new_pc_q;
                  pc_load  <= 1'b1;
                  dev_ack  <= dev_oh_q;
                  trap_ack <= trap_oh_q;
                  state    <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (state != SEQ_IDLE);
   assign mem_req  = busy;
   assign mem_addr = (state == SEQ_GET_PS) ? vec_q + DW'(2) : vec_q;
   assign psw_out  = psw_q;

   // level of the device the selector picked, for checking only
   int win_lvl;
   always_comb begin
      win_lvl = 0;
      for (int i = 0; i < NDEV; i++) begin
         if (win_dev_oh[i]) win_lvl = DEV_LVL[i];
      end
   end

   // R1
   dev_above_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !win_trap) |-> (win_lvl > int'(psw_q[PRI_LSB +: PRI_W])));
   // R2
   trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (|trap_req)) |-> (win_trap && win_dev_oh == '0));
   // R5
   boundary_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(insn_boundary) && $past(irq_pending)));
   // R6
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R7
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_ack, trap_ack}));
   // R7
   ack_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dev_ack) || (|trap_ack)) |-> pc_load);

endmodule

// File: tb/test_irq_trap_arbiter.sv
module test_irq_trap_arbiter;

   localparam int NDEV = 8;
   localparam int NTRAP = 11;

   typedef struct packed {
      logic [15:0]      pc;
      logic [15:0]      psw;
      logic [NDEV-1:0]  dack;
      logic [NTRAP-1:0] tack;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NDEV-1:0]  dev_req = '0;
   logic [NDEV-1:0]  dev_ack;
   logic [NTRAP-1:0] trap_req = '0;
   logic [NTRAP-1:0] trap_ack;
   logic             insn_boundary = 1'b0;
   logic             rtt_strobe = 1'b0;
   logic [15:0]      cur_pc = '0;
   logic             psw_wr = 1'b0;
   logic [15:0]      psw_wdata = '0;
   logic             irq_pending, busy, mem_req, pc_load;
   logic [15:0]      mem_addr, pc_out, psw_out;
   logic             mem_ack = 1'b0;
   logic [15:0]      mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   exp_t        exp_q[$];
   string       tag_q[$];
   logic [15:0] spc[$];
   logic [15:0] spsw[$];
   logic [15:0] mpsw = '0;
   logic [15:0] next_pc = 16'h4000;

   always #10 clk = ~clk;

   irq_trap_arbiter i_irq_trap_arbiter (
      .clk(clk), .rst_n(rst_n),
      .dev_req(dev_req), .dev_ack(dev_ack),
      .trap_req(trap_req), .trap_ack(trap_ack),
      .insn_boundary(insn_boundary), .rtt_strobe(rtt_strobe),
      .cur_pc(cur_pc), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
      .irq_pending(irq_pending), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pc_load(pc_load), .pc_out(pc_out), .psw_out(psw_out)
   );

   function automatic int lvl_of(int v);
      case (v)
         'o60, 'o64, 'o70, 'o74, 'o200: return 4;
         'o100, 'o104:                  return 6;
         'o220:                         return 5;
         default:                       return 7;
      endcase
   endfunction

   // stored status word: prev-mode bits deliberately 2'b10
   function automatic logic [15:0] mem_psw(int v);
      return 16'h2000 | 16'(lvl_of(v) << 5) | 16'((v >> 2) & 31);
   endfunction

   function automatic logic [15:0] mem_word(logic [15:0] a);
      if (a[1] == 1'b0) return 16'h1000 + a;
      return mem_psw(int'(a) - 2);
   endfunction

   // memory responder: one-cycle acknowledge
   initial begin
      forever begin
         @(posedge clk);
         mem_ack   <= mem_req && !mem_ack;
         mem_rdata <= mem_word(mem_addr);
      end
   end

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // monitor: scoreboard of pc_load events
   initial begin
      forever begin
         @(negedge clk);
         if (pc_load) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected pc_load", {16'h0, pc_out}, 32'h0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(pc_out == e.pc && psw_out == e.psw && dev_ack == e.dack
                     && trap_ack == e.tack, t, "pc/psw/acks",
                     {pc_out, psw_out}, {e.pc, e.psw});
            end
         end
      end
   end

   task automatic wait_load(input string tag);
      int n = 0;
      while (!pc_load && n < 40) begin
         @(negedge clk);
         n++;
      end
      if (!pc_load) check(1'b0, tag, "no pc_load", 32'h0, 32'h1);
   endtask

   task automatic take(input int v, input logic [NDEV-1:0] dack,
                       input logic [NTRAP-1:0] tack, input string tag);
      logic [15:0] epsw;
      exp_t e;
      cur_pc  = next_pc;
      next_pc = next_pc + 16'h2;
      epsw = (mem_psw(v) & 16'hCFFF) | {2'b00, mpsw[15:14], 12'h000};
      e.pc = 16'h1000 + 16'(v); e.psw = epsw; e.dack = dack; e.tack = tack;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      repeat (2) @(negedge clk);
      insn_boundary = 1'b1;
      @(negedge clk);
      insn_boundary = 1'b0;
      wait_load(tag);
      spc.push_back(cur_pc);
      spsw.push_back(mpsw);
      mpsw = epsw;
      dev_req  = dev_req & ~dack;
      trap_req = trap_req & ~tack;
   endtask

   task automatic do_rtt(input string tag);
      exp_t e;
      e.pc = spc.pop_back(); e.psw = spsw.pop_back(); e.dack = '0; e.tack = '0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      rtt_strobe = 1'b1;
      @(negedge clk);
      rtt_strobe = 1'b0;
      wait_load(tag);
      mpsw = e.psw;
   endtask

   task automatic expect_idle(input int n, input string tag);
      logic bad = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (busy || pc_load || mem_req) bad = 1'b1;
      end
      check(!bad && psw_out == mpsw, tag, "expected no entry",
            {16'h0, psw_out}, {16'h0, mpsw});
   endtask

   task automatic boundary_blocked(input string tag);
      repeat (2) @(negedge clk);
      insn_boundary = 1'b1;
      @(negedge clk);
      insn_boundary = 1'b0;
      expect_idle(4, tag);
   endtask

   task automatic write_psw(input logic [15:0] v);
      psw_wr = 1'b1; psw_wdata = v;
      @(negedge clk);
      psw_wr = 1'b0;
      check(psw_out == v, "R12", "psw write", {16'h0, psw_out}, {16'h0, v});
      mpsw = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(psw_out == 16'h0 && !busy && !mem_req && !pc_load && !irq_pending
            && dev_ack == '0 && trap_ack == '0, "R11", "reset state",
            {16'h0, psw_out}, 32'h0);

      // R12: user mode, priority 0
      write_psw(16'hC000);

      // R5: flag is registered, and nothing starts without a boundary
      dev_req[0] = 1'b1;
      #1;
      check(irq_pending == 1'b0, "R5", "flag before clock", {31'h0, irq_pending}, 32'h0);
      @(negedge clk);
      check(irq_pending == 1'b1, "R5", "flag after clock", {31'h0, irq_pending}, 32'h1);
      expect_idle(5, "R5");

      // R7: entry with previous-mode substitution (user -> 2'b11)
      take('o60, 8'b0000_0001, '0, "R7");
      // R8: single return
      do_rtt("R8");
      // R9: return with nothing saved
      rtt_strobe = 1'b1;
      @(negedge clk);
      rtt_strobe = 1'b0;
      expect_idle(3, "R9");

      // R1: level 4 at priority 4 is held
      write_psw(16'h0080);
      dev_req[1] = 1'b1;
      boundary_blocked("R1");
      check(irq_pending == 1'b0, "R1", "equal level not pending", {31'h0, irq_pending}, 32'h0);
      // R4: disk (level 5) is taken over pending teletype
      dev_req[7] = 1'b1;
      take('o220, 8'b1000_0000, '0, "R4");
      boundary_blocked("R1");
      do_rtt("R8");
      boundary_blocked("R1");
      write_psw(16'h0060);
      take('o64, 8'b0000_0010, '0, "R1");
      do_rtt("R8");

      // R4: tie at level 6 resolves to the lower vector
      write_psw(16'h0000);
      dev_req[4] = 1'b1; dev_req[5] = 1'b1; dev_req[2] = 1'b1;
      take('o100, 8'b0001_0000, '0, "R4");
      boundary_blocked("R1");
      do_rtt("R8");
      take('o104, 8'b0010_0000, '0, "R4");
      do_rtt("R8");
      take('o70, 8'b0000_0100, '0, "R4");
      do_rtt("R8");

      // R2: trap at priority 7 beats a pending device
      write_psw(16'h00E0);
      dev_req[6] = 1'b1;
      trap_req[4] = 1'b1;
      take('o24, '0, 11'b000_0001_0000, "R2");
      do_rtt("R8");
      boundary_blocked("R1");
      dev_req = '0;

      // R3: lowest trap vector first, then nesting and LIFO returns
      write_psw(16'h0000);
      trap_req[8] = 1'b1; trap_req[2] = 1'b1; dev_req[5] = 1'b1;
      take('o14, '0, 11'b000_0000_0100, "R3");
      take('o240, '0, 11'b001_0000_0000, "R3");
      do_rtt("R8");
      do_rtt("R8");
      dev_req = '0;

      // R10: save stack full holds the next event
      for (int k = 0; k < 4; k++) begin
         trap_req[0] = 1'b1;
         take('o4, '0, 11'b000_0000_0001, "R10");
      end
      trap_req[0] = 1'b1;
      repeat (2) @(negedge clk);
      check(irq_pending == 1'b1, "R10", "still pending", {31'h0, irq_pending}, 32'h1);
      boundary_blocked("R10");
      do_rtt("R8");
      take('o4, '0, 11'b000_0000_0001, "R10");
      for (int k = 0; k < 4; k++) do_rtt("R8");
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule